// File: doc/BRIEF.md
# Byte Significance Codec

This block shrinks a two's-complement data word down to the low-order bytes that carry its numeric value. It also performs the reverse step. On the compress side a full word comes in. Any upper byte that only repeats the sign of the byte beneath it is dropped. The block returns a short tag that gives the number of kept bytes, a payload bus that holds those bytes in their original lanes, and a per-byte valid mask. Downstream logic can use the mask to switch off the lanes that hold no information.

On the expand side a tag and a payload come in, and the block rebuilds the full word. Lanes above the kept range are filled with the sign bit of the highest kept byte. Both directions are pure combinational logic. A parameter can add one register stage after each direction. The word width is set by the byte count and the byte width. With the default of four 8-bit bytes the tag is two bits wide.

Top module: `sigc_codec`

## Requirements
- R1: The compress tag equals the byte count minus the number of kept bytes. With four bytes, tag 2'b11 means one kept byte, 2'b10 means two, 2'b01 means three and 2'b00 means all four.
- R2: Byte i+1 counts as insignificant when it is 8'h00 and bit 7 of byte i is 0, or when it is 8'hFF and bit 7 of byte i is 1. The kept count is the smallest count for which every byte above it is insignificant, so 32'h0000007F keeps one byte and 32'h00000080 keeps two.
- R3: The kept range is set by the highest significant byte. An insignificant byte that sits below a significant one is still kept: 32'h0000FF80 gives tag 2'b01 and 32'h00FFFF80 gives tag 2'b00.
- R4: The valid mask, with bit i for byte i, is a contiguous run of ones that starts at bit 0. Its length equals the kept count.
- R5: Each kept byte appears on the payload bus in its original byte lane. Every lane outside the kept range is driven to zero.
- R6: On expansion, byte lanes below the tag's kept count are copied from the payload. Every higher lane is filled with bit 7 of the highest kept payload byte, and payload bytes in those higher lanes have no effect on the output.
- R7: Expanding the tag and payload produced by compression returns the original word exactly, for every input word.
- R8: With REG_OUT=1 each output changes one clock after its inputs and holds its value until then. While rst_n is low the outputs are tag 2'b11, mask 4'b0001, payload 0 and expanded word 0.
- R9: The word 32'hFFFFF504 compresses to tag 2'b10, mask 4'b0011 and payload 32'h0000F504.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_word_i | input | 32 | Word to compress |
| cmp_tag_o | output | 2 | Tag giving the kept byte count |
| cmp_bytes_o | output | 32 | Kept bytes in their own lanes, other lanes zero |
| cmp_mask_o | output | 4 | Valid flag per byte lane |
| exp_tag_i | input | 2 | Tag of the word to rebuild |
| exp_bytes_i | input | 32 | Payload of the word to rebuild |
| exp_word_o | output | 32 | Rebuilt full word |

## Verification
A fault in the sign-extension detection or in the highest-byte search shows up one clock later as a wrong tag, a mask of the wrong length, or a payload lane that is not zero. A tag that is too short also breaks the round trip at the same edge, because the rebuilt upper bytes then take a sign that differs from the original. An expander fault shows up as upper lanes that do not match the top kept byte, or as leakage from the ignored payload lanes. The sweeps pick byte values on both sides of every sign boundary in every lane, so each such fault appears in the first vector that reaches the affected lane.

// File: rtl/sigc_pkg.sv
package sigc_pkg;
   // Default geometry of the codec
   localparam int unsigned SIGC_DEF_BYTES  = 4;
   localparam int unsigned SIGC_DEF_BYTE_W = 8;

   // Number of tag bits needed to encode 1..bytes kept bytes
   function automatic int unsigned sigc_tag_w(input int unsigned bytes);
      return (bytes < 2) ? 1 : $clog2(bytes);
   endfunction
endpackage

// File: rtl/sigc_ext_detect.sv
// Flags each byte lane that carries information beyond sign extension.
module sigc_ext_detect #(
   parameter int unsigned BYTES  = 4,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTES*BYTE_W-1:0] word_i,
   output logic [BYTES-1:0]        sig_o
);
   // Byte 0 always carries value
   assign sig_o[0] = 1'b1;

   for (genvar gi = 1; gi < BYTES; gi++) begin : g_lane
      logic              below_msb;
      logic [BYTE_W-1:0] lane;
      assign below_msb = word_i[gi*BYTE_W-1];
      assign lane      = word_i[gi*BYTE_W +: BYTE_W];
      assign sig_o[gi] = (lane != {BYTE_W{below_msb}});
   end
endmodule

// File: rtl/sigc_tag_enc.sv
// Finds the highest significant lane and derives tag and lane mask.
module sigc_tag_enc #(
   parameter int unsigned BYTES = 4,
   parameter int unsigned TAG_W = 2
) (
   input  logic [BYTES-1:0] sig_i,
   output logic [TAG_W-1:0] tag_o,
   output logic [BYTES-1:0] mask_o
);
   int unsigned hi;

   always_comb begin
      hi = 0;
      for (int unsigned i = 0; i < BYTES; i++) begin
         if (sig_i[i]) hi = i;
      end
      tag_o = TAG_W'(BYTES - 1 - hi);
      for (int unsigned i = 0; i < BYTES; i++) begin
         mask_o[i] = (i <= hi);
      end
   end
endmodule

// File: rtl/sigc_expand.sv
// Rebuilds a full word from tag and payload by sign filling upper lanes.
module sigc_expand #(
   parameter int unsigned BYTES  = 4,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned TAG_W  = 2
) (
   input  logic [TAG_W-1:0]        tag_i,
   input  logic [BYTES*BYTE_W-1:0] bytes_i,
   output logic [BYTES*BYTE_W-1:0] word_o
);
   int unsigned kept;
   logic        fill;

   always_comb begin
      // Tags past the last legal value clamp to a single kept byte
      if (int'(tag_i) >= int'(BYTES)) kept = 1;
      else                            kept = BYTES - int'(tag_i);
      fill = 1'b0;
      for (int unsigned j = 0; j < BYTES; j++) begin
         if (j + 1 == kept) fill = bytes_i[j*BYTE_W + BYTE_W - 1];
      end
      for (int unsigned j = 0; j < BYTES; j++) begin
         if (j < kept) word_o[j*BYTE_W +: BYTE_W] = bytes_i[j*BYTE_W +: BYTE_W];
         else          word_o[j*BYTE_W +: BYTE_W] = {BYTE_W{fill}};
      end
   end
endmodule

// File: rtl/sigc_codec.sv
// Byte significance codec: compress and expand paths, optional output stage.
module sigc_codec
   import sigc_pkg::*;
#(
   parameter int unsigned BYTES   = SIGC_DEF_BYTES,
   parameter int unsigned BYTE_W  = SIGC_DEF_BYTE_W,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [BYTES*BYTE_W-1:0]       cmp_word_i,
   output logic [sigc_tag_w(BYTES)-1:0]  cmp_tag_o,
   output logic [BYTES*BYTE_W-1:0]       cmp_bytes_o,
   output logic [BYTES-1:0]              cmp_mask_o,
   input  logic [sigc_tag_w(BYTES)-1:0]  exp_tag_i,
   input  logic [BYTES*BYTE_W-1:0]       exp_bytes_i,
   output logic [BYTES*BYTE_W-1:0]       exp_word_o
);
   localparam int unsigned TAG_W  = sigc_tag_w(BYTES);
   localparam int unsigned WORD_W = BYTES * BYTE_W;

   // Elaboration checks on the geometry
   if (BYTES < 2) begin : g_bad_bytes
      $error("sigc_codec: BYTES must be at least 2");
   end
   if (BYTE_W < 2) begin : g_bad_width
      $error("sigc_codec: BYTE_W must be at least 2");
   end
   if ((1 << TAG_W) != BYTES) begin : g_bad_pow2
      $error("sigc_codec: BYTES must be a power of two");
   end

   logic [BYTES-1:0]  sig_c;
   logic [TAG_W-1:0]  tag_c;
   logic [BYTES-1:0]  mask_c;
   logic [WORD_W-1:0] bytes_c;
   logic [WORD_W-1:0] word_c;

   sigc_ext_detect #(.BYTES(BYTES), .BYTE_W(BYTE_W)) i_detect (
      .word_i (cmp_word_i),
      .sig_o  (sig_c)
   );

   sigc_tag_enc #(.BYTES(BYTES), .TAG_W(TAG_W)) i_tag_enc (
      .sig_i  (sig_c),
      .tag_o  (tag_c),
      .mask_o (mask_c)
   );

   // Zero the lanes that the mask does not cover
   for (genvar gl = 0; gl < BYTES; gl++) begin : g_pay
      assign bytes_c[gl*BYTE_W +: BYTE_W] =
         cmp_word_i[gl*BYTE_W +: BYTE_W] & {BYTE_W{mask_c[gl]}};
   end

   sigc_expand #(.BYTES(BYTES), .BYTE_W(BYTE_W), .TAG_W(TAG_W)) i_expand (
      .tag_i   (exp_tag_i),
      .bytes_i (exp_bytes_i),
      .word_o  (word_c)
   );

   if (REG_OUT) begin : g_reg
      // Reset values encode the word zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_tag_o   <= TAG_W'(BYTES - 1);
            cmp_mask_o  <= BYTES'(1);
            cmp_bytes_o <= '0;
            exp_word_o  <= '0;
         end else begin
            cmp_tag_o   <= tag_c;
            cmp_mask_o  <= mask_c;
            cmp_bytes_o <= bytes_c;
            exp_word_o  <= word_c;
         end
      end
   end else begin : g_comb
      assign cmp_tag_o   = tag_c;
      assign cmp_mask_o  = mask_c;
      assign cmp_bytes_o = bytes_c;
      assign exp_word_o  = word_c;
   end
endmodule

// File: rtl/sigc_codec_chk.sv
// Property checker bound to the codec top.
module sigc_codec_chk #(
   parameter int unsigned BYTES   = 4,
   parameter int unsigned BYTE_W  = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic [BYTES*BYTE_W-1:0]                 cmp_word_i,
   input logic [sigc_pkg::sigc_tag_w(BYTES)-1:0]  cmp_tag_o,
   input logic [BYTES*BYTE_W-1:0]                 cmp_bytes_o,
   input logic [BYTES-1:0]                        cmp_mask_o,
   input logic [sigc_pkg::sigc_tag_w(BYTES)-1:0]  exp_tag_i,
   input logic [BYTES*BYTE_W-1:0]                 exp_bytes_i,
   input logic [BYTES*BYTE_W-1:0]                 exp_word_o
);
   localparam int unsigned TW = sigc_pkg::sigc_tag_w(BYTES);
   localparam int unsigned W  = BYTES * BYTE_W;

   logic [W-1:0]  word_d;
   logic [TW-1:0] xtag_d;
   logic [W-1:0]  xbytes_d;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_d   <= '0;
            xtag_d   <= TW'(BYTES - 1);
            xbytes_d <= '0;
         end else begin
            word_d   <= cmp_word_i;
            xtag_d   <= exp_tag_i;
            xbytes_d <= exp_bytes_i;
         end
      end
   end else begin : g_nodly
      assign word_d   = cmp_word_i;
      assign xtag_d   = exp_tag_i;
      assign xbytes_d = exp_bytes_i;
   end

   int          kept;
   int          xkept;
   logic        mask_run, clean, minimal, sgn, xsgn, xlow_ok, xfill_ok;
   logic [W-1:0] rebuilt;

   always_comb begin
      kept     = $countones(cmp_mask_o);
      mask_run = cmp_mask_o[0] && ((cmp_mask_o & (cmp_mask_o + 1'b1)) == '0);
      clean    = 1'b1;
      minimal  = 1'b1;
      sgn      = 1'b0;
      for (int j = 0; j < int'(BYTES); j++) begin
         if (!cmp_mask_o[j] && cmp_bytes_o[j*BYTE_W +: BYTE_W] != '0) clean = 1'b0;
         if (j + 1 == kept) sgn = cmp_bytes_o[j*BYTE_W + BYTE_W - 1];
         if (j + 1 == kept && j > 0 &&
             cmp_bytes_o[j*BYTE_W +: BYTE_W] == {BYTE_W{cmp_bytes_o[j*BYTE_W - 1]}})
            minimal = 1'b0;
      end
      for (int j = 0; j < int'(BYTES); j++) begin
         if (j < kept) rebuilt[j*BYTE_W +: BYTE_W] = cmp_bytes_o[j*BYTE_W +: BYTE_W];
         else          rebuilt[j*BYTE_W +: BYTE_W] = {BYTE_W{sgn}};
      end
      xkept = int'(BYTES) - int'(xtag_d);
      if (xkept < 1) xkept = 1;
      xsgn = 1'b0;
      for (int j = 0; j < int'(BYTES); j++) begin
         if (j + 1 == xkept) xsgn = xbytes_d[j*BYTE_W + BYTE_W - 1];
      end
      xlow_ok  = 1'b1;
      xfill_ok = 1'b1;
      for (int j = 0; j < int'(BYTES); j++) begin
         if (j < xkept) begin
            if (exp_word_o[j*BYTE_W +: BYTE_W] != xbytes_d[j*BYTE_W +: BYTE_W]) xlow_ok = 1'b0;
         end else begin
            if (exp_word_o[j*BYTE_W +: BYTE_W] != {BYTE_W{xsgn}}) xfill_ok = 1'b0;
         end
      end
   end

   AST_TAG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      kept == int'(BYTES) - int'(cmp_tag_o)); // R1
   AST_TOP_BYTE_SIG: assert property (@(posedge clk) disable iff (!rst_n)
      minimal); // R2
   AST_MASK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      mask_run); // R4
   AST_PAYLOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      clean); // R5
   AST_EXP_LOW_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      xlow_ok); // R6
   AST_EXP_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      xfill_ok); // R6
   AST_ROUND_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      rebuilt == word_d); // R7
endmodule

bind sigc_codec sigc_codec_chk #(
   .BYTES   (BYTES),
   .BYTE_W  (BYTE_W),
   .REG_OUT (REG_OUT)
) i_sigc_codec_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmp_word_i  (cmp_word_i),
   .cmp_tag_o   (cmp_tag_o),
   .cmp_bytes_o (cmp_bytes_o),
   .cmp_mask_o  (cmp_mask_o),
   .exp_tag_i   (exp_tag_i),
   .exp_bytes_i (exp_bytes_i),
   .exp_word_o  (exp_word_o)
);

// File: tb/test_sigc_codec.sv
`timescale 1ns/1ps
module test_sigc_codec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cmp_word_i = '0;
   logic [1:0]  cmp_tag_o;
   logic [31:0] cmp_bytes_o;
   logic [3:0]  cmp_mask_o;
   logic [1:0]  exp_tag_i = 2'b11;
   logic [31:0] exp_bytes_i = '0;
   logic [31:0] exp_word_o;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;
   logic [31:0] lfsr = 32'h1BADF00D;
   logic [1:0]  prev_tag = 2'b11;
   logic [31:0] prev_ew = '0;

   always #2 clk = ~clk;

   sigc_codec i_sigc_codec (
      .clk(clk), .rst_n(rst_n),
      .cmp_word_i(cmp_word_i), .cmp_tag_o(cmp_tag_o),
      .cmp_bytes_o(cmp_bytes_o), .cmp_mask_o(cmp_mask_o),
      .exp_tag_i(exp_tag_i), .exp_bytes_i(exp_bytes_i),
      .exp_word_o(exp_word_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // Smallest byte count whose signed range holds w
   function automatic int fit_bytes(input logic [31:0] w);
      logic signed [31:0] s;
      logic signed [31:0] t;
      s = w;
      for (int n = 1; n < 4; n++) begin
         t = s >>> (8*n - 1);
         if (t == 0 || t == -1) return n;
      end
      return 4;
   endfunction

   function automatic logic [31:0] low_mask(input int n);
      return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 32'h1);
   endfunction

   // Sign extension of the low n bytes
   function automatic logic [31:0] sext(input logic [31:0] v, input int n);
      logic signed [31:0] t;
      t = v << (32 - 8*n);
      return 32'(t >>> (32 - 8*n));
   endfunction

   function automatic logic [7:0] pick(input int k);
      case (k)
         0: return 8'h00;  1: return 8'hFF;  2: return 8'h7F;  3: return 8'h80;
         4: return 8'h01;  5: return 8'hFE;  6: return 8'h55;  default: return 8'hAA;
      endcase
   endfunction

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
   endtask

   // Drive one vector, check hold before the edge and results after it
   task automatic apply(input logic [31:0] w, input logic [1:0] et,
                        input logic [31:0] eb, input logic [31:0] ew,
                        input string req);
      int          n;
      logic [1:0]  etag;
      @(negedge clk);
      cmp_word_i  = w;
      exp_tag_i   = et;
      exp_bytes_i = eb;
      #1;
      chk(cmp_tag_o == prev_tag, "R8", "tag hold before edge", 32'(cmp_tag_o), 32'(prev_tag));
      chk(exp_word_o == prev_ew, "R8", "word hold before edge", exp_word_o, prev_ew);
      @(negedge clk);
      n    = fit_bytes(w);
      etag = 2'(4 - n);
      chk(cmp_tag_o == etag, req, "tag (R1 R2)", 32'(cmp_tag_o), 32'(etag));
      chk(cmp_mask_o == 4'((1 << n) - 1), "R4", "mask", 32'(cmp_mask_o), 32'((1 << n) - 1));
      chk(cmp_bytes_o == (w & low_mask(n)), "R5", "payload", cmp_bytes_o, w & low_mask(n));
      chk(exp_word_o == ew, "R6 R7", "expanded word", exp_word_o, ew);
      prev_tag = etag;
      prev_ew  = ew;
   endtask

   // Round trip: feed the expected compression with junk in dropped lanes
   task automatic round(input logic [31:0] w, input string req);
      int n;
      n = fit_bytes(w);
      step_lfsr();
      apply(w, 2'(4 - n), (w & low_mask(n)) | (lfsr & ~low_mask(n)), w, req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cmp_tag_o == 2'b11, "R8", "reset tag", 32'(cmp_tag_o), 32'h3);
      chk(cmp_mask_o == 4'b0001, "R8", "reset mask", 32'(cmp_mask_o), 32'h1);
      chk(cmp_bytes_o == 32'h0, "R8", "reset payload", cmp_bytes_o, 32'h0);
      chk(exp_word_o == 32'h0, "R8", "reset word", exp_word_o, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Named corner words
      round(32'hFFFF_F504, "R9");
      chk(cmp_bytes_o == 32'h0000_F504 && cmp_tag_o == 2'b10 && cmp_mask_o == 4'b0011,
          "R9", "example word", cmp_bytes_o, 32'h0000_F504);
      round(32'h0000_007F, "R1");
      chk(cmp_tag_o == 2'b11, "R1", "one kept byte", 32'(cmp_tag_o), 32'h3);
      round(32'h0000_0080, "R2");
      chk(cmp_tag_o == 2'b10, "R2", "sign boundary", 32'(cmp_tag_o), 32'h2);
      round(32'h0000_FF80, "R3");
      chk(cmp_tag_o == 2'b01 && cmp_bytes_o == 32'h0000_FF80, "R3", "inner byte kept",
          cmp_bytes_o, 32'h0000_FF80);
      round(32'h00FF_FF80, "R3");
      chk(cmp_tag_o == 2'b00, "R3", "full word kept", 32'(cmp_tag_o), 32'h0);

      // Structured sweep over boundary byte values in every lane
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            for (int c = 0; c < 8; c++)
               for (int d = 0; d < 8; d++)
                  round({pick(a), pick(b), pick(c), pick(d)}, "R2");

      // Pseudo-random words
      for (int i = 0; i < 3000; i++) begin
         step_lfsr();
         round(lfsr, "R7");
      end

      // Expander alone with arbitrary tags and payloads
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] pay;
         logic [1:0]  t;
         step_lfsr();
         pay = lfsr;
         step_lfsr();
         t = lfsr[1:0];
         apply(cmp_word_i, t, pay, sext(pay, 4 - int'(t)), "R6");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule